// File: doc/BRIEF.md
# Edge-Interrupt GPIO Port Controller

This block is an eight-pin general-purpose I/O port. A small synchronous register bus controls it. Each pin can be switched between input and output. The data register drives output pins. A read of that register returns the pin levels for input pins and the stored value for output pins. Pull-device enable and pull-select settings go straight to pad control outputs.

Every pin level first passes through a two-flop synchronizer. It then goes through a glitch filter, which accepts a new level only after it has held for `FILT_LEN` consecutive clocks, and then into an edge detector. Each pin's active edge follows its pull-select bit: rising when the pull-down is selected, falling otherwise. An active edge sets a sticky flag. Software clears a flag by writing 1 to it.

A single registered interrupt line is raised whenever any pin has both its flag and its enable set. Edge detection also sees pins that are driven as outputs, because the pad level loops back into `pin_in`.

Top module: `gpio_edge_port`

## Requirements
- R1: After synchronous reset, every register reads 0x00. `irq`, `pin_oe`, `pin_out`, `pad_pull_en` and `pad_pull_sel` are all 0.
- R2: A write to the direction register (address 0) appears on `pin_oe` after the writing edge. A write to the data register (address 1) appears on `pin_out`. Bit value 1 means the pin drives.
- R3: A read of address 1 returns the data register bit for pins with direction 1. For pins with direction 0 it returns the two-flop synchronized `pin_in` level. Read data is registered and is valid one cycle after the read request. Unused addresses 6 and 7 read 0.
- R4: A change of pin level that lasts fewer than `FILT_LEN` consecutive synchronized samples never sets a flag.
- R5: With pull-select bit 1 (address 3), a rising filtered edge sets that pin's flag and a falling edge does not.
- R6: With pull-select bit 0, a falling filtered edge sets that pin's flag and a rising edge does not.
- R7: A flag (address 5, bit n = pin n) stays set until cleared. Writing 1 to a flag bit clears it, and writing 0 to it leaves it unchanged.
- R8: If an active edge and a write-1 clear hit the same flag bit in the same cycle, the flag ends up set.
- R9: `irq` is registered. It equals the OR over pins of (flag AND enable) from the previous cycle. The enable register is at address 4.
- R10: A flag whose enable bit is 0 still sets, but it does not raise `irq`.
- R11: Edges on pins configured as outputs, looped back through `pin_in`, set flags the same way as edges on input pins.
- R12: Suppose a pin level is first sampled at clock edge E and then held. The flag becomes set at edge E+FILT_LEN+2, and `irq` rises at edge E+FILT_LEN+3.
- R13: The pull-enable (address 2) and pull-select (address 3) registers read back the values written. They drive `pad_pull_en` and `pad_pull_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | NPINS | Write data |
| bus_rdata | output | NPINS | Registered read data |
| pin_in | input | NPINS | Pad input levels |
| pin_out | output | NPINS | Pad output data |
| pin_oe | output | NPINS | Pad output enable |
| pad_pull_en | output | NPINS | Pull device enable to pads |
| pad_pull_sel | output | NPINS | Pull select, 1 = pull-down |
| irq | output | 1 | Combined port interrupt |

## Verification
The bench builds the block with its defaults: eight pins and a filter length of 4. With a short filter, pulses of exactly FILT_LEN-1 and FILT_LEN samples fit in a few cycles, so both sides of the rejection threshold are exercised. The fixed latency from a pin change to the flag also becomes cheap to hit exactly, so the bench can land a clear write on the same cycle as a detected edge. A behavioural model tracks the flags, the read data and the interrupt on every clock. Directed reads and cycle-exact `irq` samples pin down the corner cases.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_DIR      = 3'd0,
    REG_DATA     = 3'd1,
    REG_PULL_EN  = 3'd2,
    REG_PULL_SEL = 3'd3,
    REG_IRQ_EN   = 3'd4,
    REG_IRQ_FLAG = 3'd5
  } reg_addr_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage_q[s] <= '0;
          else     stage_q[s] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage_q[s] <= '0;
          else     stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_glitch_filter.sv
module gpio_glitch_filter #(
  parameter int FILT_LEN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic raw,
  output logic lvl
);
  localparam int CNT_W = (FILT_LEN > 1) ? $clog2(FILT_LEN) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FILT_LEN - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             lvl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      lvl_q <= 1'b0;
    end else if (raw != lvl_q) begin
      if (cnt_q == LAST) begin
        lvl_q <= raw;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else begin
      cnt_q <= '0;
    end
  end

  assign lvl = lvl_q;
endmodule

// File: rtl/gpio_edge_flags.sv
module gpio_edge_flags #(
  parameter int NPINS = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] lvl,
  input  logic [NPINS-1:0] rise_sel,
  input  logic [NPINS-1:0] clr,
  output logic [NPINS-1:0] edge_hit,
  output logic [NPINS-1:0] flag
);
  logic [NPINS-1:0] prev_q;
  logic [NPINS-1:0] flag_q;

  always_comb begin
    for (int i = 0; i < NPINS; i++) begin
      edge_hit[i] = rise_sel[i] ? (lvl[i] & ~prev_q[i]) : (~lvl[i] & prev_q[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '0;
      flag_q <= '0;
    end else begin
      prev_q <= lvl;
      flag_q <= (flag_q & ~clr) | edge_hit;
    end
  end

  assign flag = flag_q;
endmodule

// File: rtl/gpio_edge_port.sv
module gpio_edge_port
  import gpio_edge_pkg::*;
#(
  parameter int NPINS    = 8,
  parameter int FILT_LEN = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NPINS-1:0]  bus_wdata,
  output logic [NPINS-1:0]  bus_rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe,
  output logic [NPINS-1:0]  pad_pull_en,
  output logic [NPINS-1:0]  pad_pull_sel,
  output logic              irq
);
  logic [NPINS-1:0] dir_q, data_q, pen_q, psel_q, ien_q, rdata_q;
  logic [NPINS-1:0] sync_lvl, filt_lvl, flag_q, edge_hit, clr_mask;
  logic             irq_q;
  logic             wr_en, rd_en;

  assign wr_en = bus_sel & bus_wr;
  assign rd_en = bus_sel & ~bus_wr;

  gpio_sync #(.W(NPINS), .STAGES(2)) sync_i (
    .clk(clk), .rst(rst), .d(pin_in), .q(sync_lvl)
  );

  generate
    for (genvar p = 0; p < NPINS; p++) begin : g_filt
      gpio_glitch_filter #(.FILT_LEN(FILT_LEN)) filt_i (
        .clk(clk), .rst(rst), .raw(sync_lvl[p]), .lvl(filt_lvl[p])
      );
    end
  endgenerate

  assign clr_mask = (wr_en && bus_addr == REG_IRQ_FLAG) ? bus_wdata : '0;

  gpio_edge_flags #(.NPINS(NPINS)) flags_i (
    .clk(clk), .rst(rst), .lvl(filt_lvl), .rise_sel(psel_q),
    .clr(clr_mask), .edge_hit(edge_hit), .flag(flag_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q  <= '0;
      data_q <= '0;
      pen_q  <= '0;
      psel_q <= '0;
      ien_q  <= '0;
    end else if (wr_en) begin
      case (reg_addr_e'(bus_addr))
        REG_DIR:      dir_q  <= bus_wdata;
        REG_DATA:     data_q <= bus_wdata;
        REG_PULL_EN:  pen_q  <= bus_wdata;
        REG_PULL_SEL: psel_q <= bus_wdata;
        REG_IRQ_EN:   ien_q  <= bus_wdata;
        default:      ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (rd_en) begin
      case (reg_addr_e'(bus_addr))
        REG_DIR:      rdata_q <= dir_q;
        REG_DATA:     rdata_q <= (data_q & dir_q) | (sync_lvl & ~dir_q);
        REG_PULL_EN:  rdata_q <= pen_q;
        REG_PULL_SEL: rdata_q <= psel_q;
        REG_IRQ_EN:   rdata_q <= ien_q;
        REG_IRQ_FLAG: rdata_q <= flag_q;
        default:      rdata_q <= '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |(flag_q & ien_q);
  end

  assign bus_rdata    = rdata_q;
  assign pin_out      = data_q;
  assign pin_oe       = dir_q;
  assign pad_pull_en  = pen_q;
  assign pad_pull_sel = psel_q;
  assign irq          = irq_q;
endmodule

// File: rtl/gpio_edge_port_chk.sv
module gpio_edge_port_chk
  import gpio_edge_pkg::*;
#(
  parameter int NPINS = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [NPINS-1:0]  bus_wdata,
  input logic [NPINS-1:0]  pin_oe,
  input logic              irq,
  input logic [NPINS-1:0]  flag_q,
  input logic [NPINS-1:0]  ien_q,
  input logic [NPINS-1:0]  edge_hit,
  input logic [NPINS-1:0]  sync_lvl,
  input logic [NPINS-1:0]  filt_lvl
);
  // R2: a direction write shows on the pad enables after the edge
  p_dir_write_r2: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && bus_wr && bus_addr == REG_DIR) |=> (pin_oe == $past(bus_wdata)));

  // R4: a filtered level only moves to the value the synchronizer held
  p_filter_src_r4: assert property (@(posedge clk) disable iff (rst)
    (((filt_lvl ^ $past(filt_lvl)) & (filt_lvl ^ $past(sync_lvl))) == '0));

  // R7: without a flag write, no flag bit drops
  p_flag_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    !(bus_sel && bus_wr && bus_addr == REG_IRQ_FLAG)
      |=> ((flag_q & $past(flag_q)) == $past(flag_q)));

  // R8: a detected edge always leaves its flag set
  p_set_wins_r8: assert property (@(posedge clk) disable iff (rst)
    (edge_hit != '0) |=> ((flag_q & $past(edge_hit)) == $past(edge_hit)));

  // R9: interrupt follows enabled flags one cycle later
  p_irq_rise_r9: assert property (@(posedge clk) disable iff (rst)
    (|(flag_q & ien_q)) |=> irq);
  p_irq_fall_r9: assert property (@(posedge clk) disable iff (rst)
    !(|(flag_q & ien_q)) |=> !irq);
endmodule

bind gpio_edge_port gpio_edge_port_chk #(.NPINS(NPINS)) chk_i (
  .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .pin_oe(pin_oe), .irq(irq),
  .flag_q(flag_q), .ien_q(ien_q), .edge_hit(edge_hit),
  .sync_lvl(sync_lvl), .filt_lvl(filt_lvl)
);

// File: tb/gpio_edge_port_tb_top.sv
module gpio_edge_port_tb_top;
  localparam int N = 8;
  localparam int F = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         bus_sel = 1'b0, bus_wr = 1'b0;
  logic [2:0]   bus_addr = '0;
  logic [N-1:0] bus_wdata = '0;
  logic [N-1:0] bus_rdata, pin_in, pin_out, pin_oe, pad_pull_en, pad_pull_sel;
  logic [N-1:0] ext = '0;
  logic         irq;

  int checks = 0;
  int failures = 0;
  bit model_on = 1'b0;

  always #4 clk = ~clk;

  assign pin_in = (pin_out & pin_oe) | (ext & ~pin_oe);

  gpio_edge_port #(.NPINS(N), .FILT_LEN(F)) dut_i (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .pad_pull_en(pad_pull_en), .pad_pull_sel(pad_pull_sel), .irq(irq)
  );

  // Behavioural reference model
  logic [N-1:0] m_s1, m_s2, m_f, m_prev, m_flag, m_dir, m_out, m_pen, m_pol, m_ien, m_rd;
  bit           m_irq;
  int           m_run [N];

  always @(posedge clk) begin
    logic [N-1:0] hit, clr, nflag;
    if (rst) begin
      m_s1 = '0; m_s2 = '0; m_f = '0; m_prev = '0; m_flag = '0;
      m_dir = '0; m_out = '0; m_pen = '0; m_pol = '0; m_ien = '0; m_rd = '0;
      m_irq = 1'b0;
      for (int i = 0; i < N; i++) m_run[i] = 0;
    end else begin
      for (int i = 0; i < N; i++)
        hit[i] = m_pol[i] ? (m_f[i] && !m_prev[i]) : (!m_f[i] && m_prev[i]);
      clr = (bus_sel && bus_wr && bus_addr == 3'd5) ? bus_wdata : '0;
      nflag = (m_flag & ~clr) | hit;
      m_irq = |(m_flag & m_ien);
      if (bus_sel && !bus_wr) begin
        case (bus_addr)
          3'd0: m_rd = m_dir;
          3'd1: m_rd = (m_out & m_dir) | (m_s2 & ~m_dir);
          3'd2: m_rd = m_pen;
          3'd3: m_rd = m_pol;
          3'd4: m_rd = m_ien;
          3'd5: m_rd = m_flag;
          default: m_rd = '0;
        endcase
      end
      m_prev = m_f;
      for (int i = 0; i < N; i++) begin
        if (m_s2[i] != m_f[i]) begin
          m_run[i] = m_run[i] + 1;
          if (m_run[i] >= F) begin
            m_f[i] = m_s2[i];
            m_run[i] = 0;
          end
        end else begin
          m_run[i] = 0;
        end
      end
      m_s2 = m_s1;
      m_s1 = pin_in;
      if (bus_sel && bus_wr) begin
        case (bus_addr)
          3'd0: m_dir = bus_wdata;
          3'd1: m_out = bus_wdata;
          3'd2: m_pen = bus_wdata;
          3'd3: m_pol = bus_wdata;
          3'd4: m_ien = bus_wdata;
          default: ;
        endcase
      end
      m_flag = nflag;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [N-1:0] act,
                       input logic [N-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // Every-cycle comparison against the model
  always @(negedge clk) begin
    if (model_on) begin
      check(irq == m_irq, "R9 irq vs model", {7'b0, irq}, {7'b0, m_irq});
      check(pin_oe == m_dir, "R2 pin_oe vs model", pin_oe, m_dir);
      check(pin_out == m_out, "R2 pin_out vs model", pin_out, m_out);
      check(bus_rdata == m_rd, "R3 rdata vs model", bus_rdata, m_rd);
      check(pad_pull_sel == m_pol, "R13 pull_sel vs model", pad_pull_sel, m_pol);
    end
  end

  task automatic bus_write(input logic [2:0] a, input logic [N-1:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [N-1:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic expect_reg(input logic [2:0] a, input logic [N-1:0] mask,
                            input logic [N-1:0] exp, input string tag);
    logic [N-1:0] v;
    bus_read(a, v);
    check((v & mask) == exp, tag, v & mask, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : stim
    repeat (4) @(negedge clk);
    rst = 1'b0;
    model_on = 1'b1;
    // R1 reset state
    check(irq == 1'b0 && pin_oe == '0 && pin_out == '0 && pad_pull_en == '0,
          "R1 outputs after reset", pin_oe | pin_out | pad_pull_en, '0);
    for (int a = 0; a < 8; a++) expect_reg(3'(a), 8'hFF, 8'h00, "R1 register reset");

    // R2 / R3 direction, data and readback
    ext = 8'h3C;
    bus_write(3'd1, 8'hA5);
    bus_write(3'd0, 8'hC0);
    check(pin_oe == 8'hC0, "R2 pin_oe", pin_oe, 8'hC0);
    check(pin_out == 8'hA5, "R2 pin_out", pin_out, 8'hA5);
    idle(4);
    expect_reg(3'd1, 8'hFF, 8'hBC, "R3 mixed data read");
    expect_reg(3'd7, 8'hFF, 8'h00, "R3 unused address");

    // R13 pull settings
    bus_write(3'd2, 8'h55);
    bus_write(3'd3, 8'h0F);
    expect_reg(3'd2, 8'hFF, 8'h55, "R13 pull enable readback");
    expect_reg(3'd3, 8'hFF, 8'h0F, "R13 pull select readback");
    check(pad_pull_en == 8'h55, "R13 pad_pull_en", pad_pull_en, 8'h55);
    bus_write(3'd5, 8'hFF);
    idle(2);
    expect_reg(3'd5, 8'hFF, 8'h00, "R7 flags clear before tests");

    // R4 glitch of F-1 samples on a rising-sensitive pin
    @(negedge clk); ext[0] = 1'b1;
    idle(F - 1);
    ext[0] = 1'b0;
    idle(12);
    expect_reg(3'd5, 8'h01, 8'h00, "R4 short pulse rejected");

    // R5 pulse of exactly F samples is accepted as rising
    @(negedge clk); ext[0] = 1'b1;
    idle(F);
    ext[0] = 1'b0;
    idle(12);
    expect_reg(3'd5, 8'h01, 8'h01, "R5 rising edge flagged");

    // R6 falling-sensitive pin 5
    ext[5] = 1'b0;
    idle(12);
    expect_reg(3'd5, 8'h20, 8'h20, "R6 falling edge flagged");
    bus_write(3'd5, 8'h20);
    ext[5] = 1'b1;
    idle(12);
    expect_reg(3'd5, 8'h20, 8'h00, "R6 rising edge ignored");

    // R7 write-1-to-clear and write-0 no effect
    bus_write(3'd5, 8'h00);
    expect_reg(3'd5, 8'hFF, 8'h01, "R7 write 0 keeps flag");
    check(irq == 1'b0, "R10 flag without enable keeps irq low", {7'b0, irq}, 8'h00);
    bus_write(3'd4, 8'h01);
    idle(1);
    check(irq == 1'b1, "R9 enabled flag raises irq", {7'b0, irq}, 8'h01);
    bus_write(3'd5, 8'h01);
    idle(1);
    check(irq == 1'b0, "R9 irq drops after clear", {7'b0, irq}, 8'h00);
    expect_reg(3'd5, 8'hFF, 8'h00, "R7 write 1 clears flag");

    // R8 clear lands in the same cycle as the edge on pin 1
    @(negedge clk); ext[1] = 1'b1;
    repeat (F + 2) @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 3'd5; bus_wdata = 8'h02;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    expect_reg(3'd5, 8'h02, 8'h02, "R8 set wins over clear");
    bus_write(3'd5, 8'h02);
    expect_reg(3'd5, 8'h02, 8'h00, "R8 later clear works");

    // R11 loopback edge on output pin 6 (falling-sensitive)
    bus_write(3'd1, 8'hE5);
    idle(12);
    expect_reg(3'd5, 8'h40, 8'h00, "R11 output rising ignored");
    bus_write(3'd1, 8'hA5);
    idle(12);
    expect_reg(3'd5, 8'h40, 8'h40, "R11 output falling flagged");
    bus_write(3'd5, 8'hFF);

    // R12 latency from pin change to irq (pin 0, enabled)
    idle(2);
    @(negedge clk); ext[0] = 1'b1;
    repeat (F + 3) @(negedge clk);
    check(irq == 1'b0, "R12 irq not yet high", {7'b0, irq}, 8'h00);
    @(negedge clk);
    check(irq == 1'b1, "R12 irq high at expected edge", {7'b0, irq}, 8'h01);
    idle(4);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule